// File: doc/BRIEF.md
# Lookahead-Gated Thread Issue Controller

This block decides, every cycle, which of many hardware threads may send an instruction into a shared pipeline. It is meant for a machine with no data cache, where a memory access takes on the order of 150 cycles and latency is hidden by switching among many threads. Each instruction word is 64 bits and packs up to three operations: one memory operation, one arithmetic operation, and a third that is either arithmetic or a branch. The compiler marks each instruction with a 3-bit lookahead value. That value says how many of the thread's following instructions do not depend on it, and so may issue while its long-latency work is still in flight.

For each thread the controller keeps a state machine with three states. FREE means nothing is outstanding. WINDOW means something is outstanding and issue budget remains. BLOCKED means something is outstanding and the budget is exhausted. The transitions are: LAUNCH (FREE to WINDOW on a memory issue with nonzero lookahead), LAUNCH_TIGHT (FREE to BLOCKED on a memory issue with lookahead 0), SPEND (WINDOW to WINDOW on an issue that leaves budget), EXHAUST (WINDOW to BLOCKED when the budget reaches 0), and RELEASE (WINDOW or BLOCKED to FREE when the last outstanding operation completes). A thread is permitted while it is not BLOCKED. One permitted, requesting thread is chosen each cycle by round-robin. The choice is combinational, and the issue takes effect at the following clock edge.

Requesters present `req_i`, `req_mem_i` and the lookahead slice of `req_la_i` for each thread. They hold these until the thread is chosen. The memory side pulses `done_i` for a thread once for each completed long-latency operation.

Top module: `lti_issue_ctrl`

## Requirements
- R1: After reset every thread is permitted (`permit_o` all ones), and `issue_valid_o` is 0 while no thread requests.
- R2: A memory instruction (`req_mem_i`=1) with lookahead L, in bits [3t+2:3t] of `req_la_i`, issued by thread t with nothing outstanding, allows exactly L further issues from t. The thread is then blocked.
- R3: A memory instruction with lookahead L issued while an older operation is still outstanding sets the remaining budget to the smaller of (old budget minus 1) and L.
- R4: A blocked thread has its `permit_o` bit at 0 and is never chosen. It stays blocked until completions arrive for it.
- R5: The completion that retires a thread's last outstanding operation restores its `permit_o` bit in the next cycle. A completion that leaves other operations outstanding does not.
- R6: A `done_i` pulse for a thread that has nothing outstanding is ignored and does not corrupt later window tracking.
- R7: If a thread's only outstanding operation completes in the same cycle that it issues a new memory instruction with lookahead L, the budget becomes L. The old window no longer constrains it.
- R8: The chosen thread is the first requesting, permitted thread after the last chosen index, in increasing order with wraparound. After reset the search starts at thread 0.
- R9: `issue_valid_o` is 1 exactly when some thread is both requesting and permitted. The chosen `issue_tid_o` is always such a thread.
- R10: Non-memory instructions issued from a thread with nothing outstanding never block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_THREADS | Thread has an instruction ready to issue |
| req_mem_i | input | NUM_THREADS | The ready instruction starts a long-latency operation |
| req_la_i | input | NUM_THREADS*LA_W | Lookahead value per thread, thread t in bits [LA_W*t +: LA_W] |
| done_i | input | NUM_THREADS | One long-latency operation of the thread has completed |
| permit_o | output | NUM_THREADS | Thread is allowed to issue |
| issue_valid_o | output | 1 | A thread is chosen this cycle |
| issue_tid_o | output | $clog2(NUM_THREADS) | Index of the chosen thread |

## Verification
The hardest situation to reach from the ports is a thread that holds two overlapping windows and is then released in two steps. Reaching it needs a second memory issue while the first window still has budget, a run of plain issues until the tighter window ends, and then two separate completions. Only the second of these completions may release the thread. The stimulus sweeps every first lookahead from 1 to 7 against every second lookahead from 0 to 7, and counts the issues until the block so it can compare them with the arithmetic minimum. A separate directed case lines up a completion with a new memory issue in the same cycle, which tests the rule that a retired window is dropped.

// File: rtl/lti_pkg.sv
package lti_pkg;

    typedef enum logic [1:0] {
        CTX_FREE    = 2'd0,
        CTX_WINDOW  = 2'd1,
        CTX_BLOCKED = 2'd2
    } ctx_state_e;

endpackage

// File: rtl/lti_thread_ctx.sv
module lti_thread_ctx
    import lti_pkg::*;
#(
    parameter int LA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic            is_mem,
    input  logic [LA_W-1:0] la,
    input  logic            done,
    output logic            permit
);

    localparam int LA_MAX   = (1 << LA_W) - 1;
    localparam int MAX_OUTS = LA_MAX + 1;
    localparam int CNT_W    = $clog2(MAX_OUTS + 1);

    ctx_state_e       state_q, state_n;
    logic [LA_W-1:0]  budget_q, budget_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    logic             done_eff;
    logic             last_retires;
    logic             old_clear;
    logic             mem_issue;
    logic [LA_W-1:0]  spent;
    logic [LA_W-1:0]  tight;

    always_comb begin
        done_eff     = done && (cnt_q != '0);
        last_retires = done && (cnt_q == CNT_W'(1));
        old_clear    = (cnt_q == '0) || last_retires;
        mem_issue    = issue && is_mem;
        spent        = (budget_q == '0) ? '0 : budget_q - LA_W'(1);
        tight        = (spent < la) ? spent : la;
    end

    always_comb begin
        cnt_n = cnt_q;
        if (mem_issue && !done_eff) begin
            cnt_n = cnt_q + CNT_W'(1);
        end else if (!mem_issue && done_eff) begin
            cnt_n = cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        state_n  = state_q;
        budget_n = budget_q;
        unique case (state_q)
            CTX_FREE: begin
                if (mem_issue) begin
                    budget_n = la;
                    state_n  = (la == '0) ? CTX_BLOCKED : CTX_WINDOW;
                end
            end
            CTX_WINDOW: begin
                if (mem_issue) begin
                    budget_n = old_clear ? la : tight;
                    state_n  = (budget_n == '0) ? CTX_BLOCKED : CTX_WINDOW;
                end else if (issue) begin
                    if (old_clear) begin
                        budget_n = '0;
                        state_n  = CTX_FREE;
                    end else begin
                        budget_n = spent;
                        state_n  = (spent == '0) ? CTX_BLOCKED : CTX_WINDOW;
                    end
                end else if (last_retires) begin
                    budget_n = '0;
                    state_n  = CTX_FREE;
                end
            end
            CTX_BLOCKED: begin
                if (last_retires) begin
                    budget_n = '0;
                    state_n  = CTX_FREE;
                end
            end
            default: begin
                budget_n = '0;
                state_n  = CTX_FREE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CTX_FREE;
            budget_q <= '0;
            cnt_q    <= '0;
        end else begin
            state_q  <= state_n;
            budget_q <= budget_n;
            cnt_q    <= cnt_n;
        end
    end

    always_comb begin
        permit = (state_q != CTX_BLOCKED);
    end

endmodule

// File: rtl/lti_rr_pick.sv
module lti_rr_pick #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         elig,
    output logic                 valid,
    output logic [$clog2(N)-1:0] idx
);

    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] last_q;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            if (!valid && elig[(int'(last_q) + k) % N]) begin
                valid = 1'b1;
                idx   = IDX_W'((int'(last_q) + k) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (valid) begin
            last_q <= idx;
        end
    end

endmodule

// File: rtl/lti_issue_ctrl.sv
module lti_issue_ctrl #(
    parameter int NUM_THREADS = 16,
    parameter int LA_W        = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS-1:0]         req_i,
    input  logic [NUM_THREADS-1:0]         req_mem_i,
    input  logic [NUM_THREADS*LA_W-1:0]    req_la_i,
    input  logic [NUM_THREADS-1:0]         done_i,
    output logic [NUM_THREADS-1:0]         permit_o,
    output logic                           issue_valid_o,
    output logic [$clog2(NUM_THREADS)-1:0] issue_tid_o
);

    localparam int TID_W = $clog2(NUM_THREADS);

    logic [NUM_THREADS-1:0] elig;
    logic [NUM_THREADS-1:0] issue_vec;
    logic                   pick_valid;
    logic [TID_W-1:0]       pick_idx;

    always_comb begin
        elig = req_i & permit_o;
    end

    lti_rr_pick #(.N(NUM_THREADS)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctx
        always_comb begin
            issue_vec[t] = pick_valid && (pick_idx == TID_W'(t));
        end

        lti_thread_ctx #(.LA_W(LA_W)) u_ctx (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (issue_vec[t]),
            .is_mem (req_mem_i[t]),
            .la     (req_la_i[t*LA_W +: LA_W]),
            .done   (done_i[t]),
            .permit (permit_o[t])
        );
    end

    always_comb begin
        issue_valid_o = pick_valid;
        issue_tid_o   = pick_idx;
    end

endmodule

// File: rtl/lti_issue_ctrl_chk.sv
module lti_issue_ctrl_chk #(
    parameter int NUM_THREADS = 16,
    parameter int LA_W        = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_THREADS-1:0]         req_i,
    input logic [NUM_THREADS-1:0]         req_mem_i,
    input logic [NUM_THREADS*LA_W-1:0]    req_la_i,
    input logic [NUM_THREADS-1:0]         done_i,
    input logic [NUM_THREADS-1:0]         permit_o,
    input logic                           issue_valid_o,
    input logic [$clog2(NUM_THREADS)-1:0] issue_tid_o
);

    logic [NUM_THREADS-1:0] issued_oh;
    logic [LA_W-1:0]        chosen_la;

    always_comb begin
        issued_oh = issue_valid_o ? (NUM_THREADS'(1) << issue_tid_o) : '0;
        chosen_la = req_la_i[issue_tid_o*LA_W +: LA_W];
    end

    assert_grant_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (req_i[issue_tid_o] && permit_o[issue_tid_o]));

    assert_work_conserving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_i & permit_o)) |-> issue_valid_o);

    assert_zero_window_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && req_mem_i[issue_tid_o] && (chosen_la == '0))
        |=> !permit_o[$past(issue_tid_o)]);

    assert_blocked_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~permit_o & ~done_i)) |=> (($past(~permit_o & ~done_i) & permit_o) == '0));

    assert_idle_stays_permitted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(permit_o & ~issued_oh)) |=> (($past(permit_o & ~issued_oh) & ~permit_o) == '0));

endmodule

bind lti_issue_ctrl lti_issue_ctrl_chk #(
    .NUM_THREADS (NUM_THREADS),
    .LA_W        (LA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .req_mem_i     (req_mem_i),
    .req_la_i      (req_la_i),
    .done_i        (done_i),
    .permit_o      (permit_o),
    .issue_valid_o (issue_valid_o),
    .issue_tid_o   (issue_tid_o)
);

// File: tb/lti_issue_ctrl_bench.sv
module lti_issue_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 4;
    localparam int LW         = 3;
    localparam int TW         = $clog2(NT);

    logic            clk;
    logic            rst_n;
    logic [NT-1:0]   req;
    logic [NT-1:0]   mem;
    logic [NT*LW-1:0] la;
    logic [NT-1:0]   done;
    logic [NT-1:0]   permit;
    logic            issue_valid;
    logic [TW-1:0]   issue_tid;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    lti_issue_ctrl #(.NUM_THREADS(NT), .LA_W(LW)) u_lti_issue_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .req_mem_i     (mem),
        .req_la_i      (la),
        .done_i        (done),
        .permit_o      (permit),
        .issue_valid_o (issue_valid),
        .issue_tid_o   (issue_tid)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        req  = '0;
        mem  = '0;
        la   = '0;
        done = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue_mem(input int tid, input int lval, input bit with_done, input string tag);
        @(negedge clk);
        idle();
        req[tid]          = 1'b1;
        mem[tid]          = 1'b1;
        la[tid*LW +: LW]  = LW'(lval);
        done[tid]         = with_done;
        #1;
        check(issue_valid && (int'(issue_tid) == tid), tag, int'(issue_tid), tid);
    endtask

    task automatic count_run(input int tid, input int limit, output int n);
        n = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            idle();
            req[tid] = 1'b1;
            #1;
            if (issue_valid && (int'(issue_tid) == tid)) n++;
            else break;
        end
    endtask

    task automatic pulse_done(input int tid);
        @(negedge clk);
        idle();
        done[tid] = 1'b1;
        @(negedge clk);
        idle();
        #1;
    endtask

    function automatic int next_pick(input int last, input logic [NT-1:0] mask);
        for (int k = 1; k <= NT; k++) begin
            if (mask[(last + k) % NT]) return (last + k) % NT;
        end
        return -1;
    endfunction

    initial begin
        int cycles;
        cycles = 0;
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int n;
        int last;
        int exp_tid;
        rst_n = 1'b0;
        idle();
        do_reset();

        // R1: reset state
        #1;
        check(permit == '1, "R1 permit after reset", int'(permit), (1 << NT) - 1);
        check(!issue_valid, "R1 no issue when idle", int'(issue_valid), 0);

        // R2 / R4 / R5: single window sweep over every lookahead
        for (int L = 0; L < 8; L++) begin
            issue_mem(0, L, 1'b0, "R2 mem issue accepted");
            count_run(0, 20, n);
            check(n == L, "R2 issues inside window", n, L);
            check(!permit[0], "R4 blocked after window", int'(permit[0]), 0);
            check(permit[1], "R4 other thread unaffected", int'(permit[1]), 1);
            pulse_done(0);
            check(permit[0], "R5 released next cycle", int'(permit[0]), 1);
        end

        // R3 / R5: overlapping windows, tighter one wins
        for (int a = 1; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                int e;
                e = (a - 1 < b) ? a - 1 : b;
                issue_mem(0, a, 1'b0, "R3 first mem issue");
                issue_mem(0, b, 1'b0, "R3 second mem issue");
                count_run(0, 20, n);
                check(n == e, "R3 min window", n, e);
                pulse_done(0);
                check(!permit[0], "R5 partial completion keeps block", int'(permit[0]), 0);
                pulse_done(0);
                check(permit[0], "R5 final completion releases", int'(permit[0]), 1);
            end
        end

        // R7: completion coincides with new memory issue
        issue_mem(0, 3, 1'b0, "R7 first mem issue");
        issue_mem(0, 5, 1'b1, "R7 mem issue with completion");
        count_run(0, 20, n);
        check(n == 5, "R7 old window dropped", n, 5);
        pulse_done(0);
        check(permit[0], "R7 single completion releases", int'(permit[0]), 1);

        // R6: spurious completion ignored
        pulse_done(0);
        check(permit[0], "R6 spurious done keeps permit", int'(permit[0]), 1);
        issue_mem(0, 2, 1'b0, "R6 mem issue after spurious done");
        count_run(0, 20, n);
        check(n == 2, "R6 window intact", n, 2);
        pulse_done(0);
        check(permit[0], "R6 one completion releases", int'(permit[0]), 1);

        // R10: plain issues never block
        count_run(0, 12, n);
        check(n == 12, "R10 plain issues unlimited", n, 12);
        check(permit[0], "R10 still permitted", int'(permit[0]), 1);

        // R8: round-robin from reset
        do_reset();
        last = NT - 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            idle();
            req = '1;
            #1;
            exp_tid = next_pick(last, '1);
            check(issue_valid && (int'(issue_tid) == exp_tid), "R8 rotation", int'(issue_tid), exp_tid);
            last = int'(issue_tid);
        end

        // R8 / R9 / R4: rotation skips a blocked thread
        issue_mem(2, 0, 1'b0, "R8 block thread 2");
        @(negedge clk);
        idle();
        req[2] = 1'b1;
        #1;
        check(!issue_valid, "R9 blocked requester only", int'(issue_valid), 0);
        check(!permit[2], "R4 thread 2 blocked", int'(permit[2]), 0);
        last = 2;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            idle();
            req = '1;
            #1;
            exp_tid = next_pick(last, 4'b1011);
            check(issue_valid && (int'(issue_tid) == exp_tid), "R8 skip blocked", int'(issue_tid), exp_tid);
            last = int'(issue_tid);
        end
        pulse_done(2);
        check(permit[2], "R5 thread 2 released", int'(permit[2]), 1);

        // R9: nothing requested
        @(negedge clk);
        idle();
        #1;
        check(!issue_valid, "R9 idle no issue", int'(issue_valid), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule